// File: doc/BRIEF.md
# Receive Page Filter with Address Remap

This block sits on the receive side of a cluster interconnect adapter. Every packet that arrives from the network carries a target network address. The block looks up that address in a table of per-page attribute entries and settles what the downstream host bus engine does with the packet. It can drop the packet, write it to local memory, treat it as a request to read local memory and return the data, or treat it as a conditional write. It also decides whether the arrival should raise an interrupt. It produces the local bus address, which either passes through unchanged or has its upper bits replaced by a per-page remap field.

Software fills the table through a simple write port, one entry per cycle. A global input selects 4 KB or 8 KB pages. That choice moves the page index window within the address and sets how many offset bits pass through untouched. A link-error input narrows delivery to pages marked as safe for error recovery. Lookups use a valid/ready handshake on both sides, and the result is registered one cycle after acceptance.

Top module: `rx_page_filter`

## Requirements
- R1: After reset, `out_valid` is 0 and every table entry is cleared, so any lookup returns action 0 (discard) with no interrupt.
- R2: A page whose receive-enable attribute (bit 0 of `cfg_attr`) is clear yields action 0 (discard), with `out_irq` low.
- R3: A packet delivered (action not 0) to a page whose interrupt attribute (bit 1) is set asserts `out_irq`. Otherwise `out_irq` is low.
- R4: While `link_err` is high, only pages with the error-recovery attribute (bit 2) set are delivered. All others yield action 0.
- R5: A delivered packet on a page with the remote-read attribute (bit 3) yields action 2 (read local memory at `out_addr`, return the data as a network write to the same address).
- R6: A delivered packet on a page with the conditional-write attribute (bit 4) and without bit 3 yields action 3. A delivered packet on a page with neither bit set yields action 1 (local write).
- R7: A page with both bit 3 and bit 4 set raises `out_cfg_err` and yields action 0, whatever the other bits are.
- R8: With the remap attribute (bit 5) set, `out_addr` is `cfg_upper` placed above the page offset. With bit 5 clear, `out_addr` equals the input address. The page offset always passes through unchanged.
- R9: With `pg_large`=0, pages are 4 KB: the index is address bits [19:12], and all 20 upper bits come from the entry. With `pg_large`=1, pages are 8 KB: the index is bits [20:13], and the upper bits are `cfg_upper[19:1]` above a 13-bit offset.
- R10: An input accepted with `in_valid && in_ready` appears on the outputs one cycle later. The outputs hold steady while `out_valid && !out_ready`.
- R11: `in_ready` is low while a result is held that has not yet been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_large | input | 1 | 1 selects 8 KB pages, 0 selects 4 KB pages |
| link_err | input | 1 | Link is in error state |
| cfg_we | input | 1 | Write strobe for a table entry |
| cfg_idx | input | 8 | Entry to write |
| cfg_attr | input | 6 | Attributes: 0 rx enable, 1 irq, 2 error-ok, 3 remote read, 4 conditional write, 5 remap |
| cfg_upper | input | 20 | Upper local address bits for remap |
| in_valid | input | 1 | Network address valid |
| in_ready | output | 1 | Lookup can accept |
| in_addr | input | 32 | Network address of received packet |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Bus engine takes result |
| out_action | output | 2 | 0 discard, 1 write, 2 remote read, 3 conditional write |
| out_addr | output | 32 | Local bus address |
| out_irq | output | 1 | Interrupt request for this packet |
| out_cfg_err | output | 1 | Page has conflicting read and conditional-write attributes |

## Verification
On every cycle, assertions check the handshake: acceptance produces a result one cycle later, a held result stays stable, and the block refuses input while blocked. They also check the cross-field rules that a conflicting page is always discarded and that a discard never interrupts. The attribute decoding, the error-state gating, the remapped address bits and the shift of the index window with page size can only be shown by the bench. It sweeps all 64 attribute combinations, under both link states and both page sizes, and compares each result with an arithmetic model.

// File: rtl/rx_page_filter.sv
module rx_page_filter #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pg_large,
  input  logic                     link_err,
  input  logic                     cfg_we,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  logic [5:0]               cfg_attr,
  input  logic [ADDR_W-OFF_W-1:0]  cfg_upper,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [ADDR_W-1:0]        in_addr,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [1:0]               out_action,
  output logic [ADDR_W-1:0]        out_addr,
  output logic                     out_irq,
  output logic                     out_cfg_err
);
  localparam int UP_W    = ADDR_W - OFF_W;
  localparam int ENT_W   = 6 + UP_W;
  localparam int ENTRIES = 1 << IDX_W;

  localparam logic [1:0] ACT_DROP  = 2'd0;
  localparam logic [1:0] ACT_WRITE = 2'd1;
  localparam logic [1:0] ACT_RREAD = 2'd2;
  localparam logic [1:0] ACT_CWR   = 2'd3;

  logic [ENT_W-1:0] tbl [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else if (cfg_we) begin
      tbl[cfg_idx] <= {cfg_upper, cfg_attr};
    end
  end

  logic [IDX_W-1:0] idx;
  logic [ENT_W-1:0] ent;
  logic [5:0]       attr;
  logic [UP_W-1:0]  upper;

  assign idx   = pg_large ? in_addr[OFF_W+1 +: IDX_W] : in_addr[OFF_W +: IDX_W];
  assign ent   = tbl[idx];
  assign attr  = ent[5:0];
  assign upper = ent[ENT_W-1:6];

  logic conflict, deliver;
  logic [1:0] act;
  logic [ADDR_W-1:0] remapped, laddr;

  assign conflict = attr[3] & attr[4];
  assign deliver  = attr[0] & (~link_err | attr[2]) & ~conflict;
  assign act      = !deliver ? ACT_DROP : attr[3] ? ACT_RREAD : attr[4] ? ACT_CWR : ACT_WRITE;
  assign remapped = pg_large ? {upper[UP_W-1:1], in_addr[OFF_W:0]}
                             : {upper, in_addr[OFF_W-1:0]};
  assign laddr    = attr[5] ? remapped : in_addr;

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_action  <= ACT_DROP;
      out_addr    <= '0;
      out_irq     <= 1'b0;
      out_cfg_err <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_action  <= act;
        out_addr    <= laddr;
        out_irq     <= deliver & attr[1];
        out_cfg_err <= conflict;
      end
    end
  end

  // R10
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_action) && $stable(out_addr)
                                && $stable(out_irq) && $stable(out_cfg_err));

  // R11
  blocked_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R7
  conflict_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cfg_err |-> out_action == ACT_DROP);

  // R3
  drop_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_action == ACT_DROP |-> !out_irq);
endmodule

// File: tb/tb_rx_page_filter.sv
`timescale 1ns/1ps
module tb_rx_page_filter;
  logic clk = 0, rst_n = 0, pg_large = 0, link_err = 0;
  logic cfg_we = 0;
  logic [7:0] cfg_idx = 0;
  logic [5:0] cfg_attr = 0;
  logic [19:0] cfg_upper = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [31:0] in_addr = 0, out_addr;
  logic [1:0] out_action;
  logic out_irq, out_cfg_err;
  int errors = 0, checks = 0, cycles = 0;

  rx_page_filter dut (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] i, input logic [5:0] a, input logic [19:0] u);
    @(negedge clk);
    cfg_we = 1; cfg_idx = i; cfg_attr = a; cfg_upper = u;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic look(input logic [31:0] a, input logic le);
    @(negedge clk);
    in_valid = 1; in_addr = a; link_err = le;
    @(negedge clk);
    in_valid = 0;
  endtask

  function automatic logic [31:0] mk(input logic [7:0] i, input logic pg);
    logic [31:0] r;
    r = $urandom;
    if (pg) r[20:13] = i; else r[19:12] = i;
    return r;
  endfunction

  initial begin
    logic [31:0] a, ea;
    logic [1:0] eact;
    logic del, eirq, ecf;
    logic [19:0] up;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 out_valid", {31'b0, out_valid}, 0);
    chk("R1 in_ready", {31'b0, in_ready}, 1);
    look(32'h0000_5123, 0);
    chk("R1 cleared action", {30'b0, out_action}, 0);
    chk("R1 cleared irq", {31'b0, out_irq}, 0);

    for (int pg = 0; pg < 2; pg++) begin
      pg_large = pg[0];
      for (int k = 0; k < 64; k++) begin
        up = 20'(k * 32'h3A5C7 ^ 32'h9C3E1) + 20'(pg);
        wr(8'(k * 3 + 1), 6'(k), up);
      end
      for (int le = 0; le < 2; le++) begin
        for (int k = 0; k < 64; k++) begin
          logic [5:0] at;
          at = 6'(k);
          up = 20'(k * 32'h3A5C7 ^ 32'h9C3E1) + 20'(pg);
          a = mk(8'(k * 3 + 1), pg[0]);
          look(a, le[0]);
          ecf  = at[3] & at[4];
          del  = at[0] & (le == 0 | at[2]) & ~ecf;
          eact = !del ? 2'd0 : at[3] ? 2'd2 : at[4] ? 2'd3 : 2'd1;
          eirq = del & at[1];
          ea   = !at[5] ? a : pg ? {up[19:1], a[12:0]} : {up, a[11:0]};
          if (ecf) tag = "R7";
          else if (!at[0]) tag = "R2";
          else if (le != 0 && !at[2]) tag = "R4";
          else if (at[3]) tag = "R5";
          else tag = "R6";
          chk({tag, " action"}, {30'b0, out_action}, {30'b0, eact});
          chk("R3 irq", {31'b0, out_irq}, {31'b0, eirq});
          chk("R7 cfg_err", {31'b0, out_cfg_err}, {31'b0, ecf});
          chk(pg ? "R9 addr 8K" : "R8 addr 4K", out_addr, ea);
          chk("R10 valid", {31'b0, out_valid}, 1);
        end
      end
    end

    // R10/R11: backpressure holds result and blocks input
    wr(8'h20, 6'b100001, 20'hABCDE);
    wr(8'h21, 6'b000011, 20'h12345);
    pg_large = 0; out_ready = 0;
    @(negedge clk);
    in_valid = 1; in_addr = 32'h0002_0456; link_err = 0;
    @(negedge clk);
    in_addr = 32'h0002_1789;
    chk("R11 in_ready blocked", {31'b0, in_ready}, 0);
    chk("R10 first addr", out_addr, 32'hABCDE_456);
    @(negedge clk);
    chk("R10 held addr", out_addr, 32'hABCDE_456);
    chk("R10 held action", {30'b0, out_action}, 1);
    chk("R10 held irq", {31'b0, out_irq}, 0);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R10 second addr", out_addr, 32'h0002_1789);
    chk("R3 second irq", {31'b0, out_irq}, 1);
    @(negedge clk);
    chk("R10 drained", {31'b0, out_valid}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule